// File: doc/BRIEF.md
# Sequential Rule Packet Classifier

This block sorts packets into one of eight degradation queues. Each packet arrives as a reference tag and four header fields taken from its IPv4 header: the protocol number, the type-of-service byte, the source address and the destination address. The block returns the same reference together with a 3-bit queue number. Queue 7 is reserved for packets that no rule claims.

A host fills a small table of rules through a simple write port. Each rule holds a value and a bit mask that cover all four fields, an enable bit and a target queue. After a packet is accepted, the rules are tried one per clock in ascending index order. All rules are compared against a single registered copy of the header. The first enabled rule that matches stops the scan. The block takes one packet at a time: it raises its input ready again only after the result has been passed downstream.

Top module: `pkt_cls`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and every rule is disabled, so any packet is placed in queue 7.
- R2: A rule matches when every header bit whose mask bit is 1 equals the rule's value bit. The 80-bit header, value and mask layout is: protocol in [79:72], type-of-service in [71:64], source address in [63:32], destination address in [31:0].
- R3: The result queue is the `cfg_qid` of the lowest-indexed enabled rule that matches.
- R4: A packet that no enabled rule matches is placed in queue 7.
- R5: A rule written with `cfg_en` = 0 never matches, even if its mask is all zeros.
- R6: For a packet accepted at clock edge k, `out_valid` rises after edge k+1+i when rule i is the winner, and after edge k+NUM_RULES when no rule matches.
- R7: `in_ready` is high only when no packet is held. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_qid` and `out_ref` stay unchanged.
- R8: A write with `cfg_we` = 1 while `in_ready` is low has no effect on the table.
- R9: `out_ref` equals the `in_ref` that was captured when the packet was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet is offered |
| in_ready | output | 1 | Block is idle and will accept a packet |
| in_ref | input | REF_W | Packet reference tag |
| in_proto | input | 8 | IP protocol number |
| in_tos | input | 8 | Type-of-service byte |
| in_src | input | 32 | Source IPv4 address |
| in_dst | input | 32 | Destination IPv4 address |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | IDX_W | Index of the rule being written |
| cfg_en | input | 1 | Enable bit for the written rule |
| cfg_qid | input | 3 | Target queue for the written rule |
| cfg_value | input | 80 | Match value, laid out as in R2 |
| cfg_mask | input | 80 | Match mask, laid out as in R2 |
| out_valid | output | 1 | A classification result is available |
| out_ready | input | 1 | Downstream takes the result |
| out_ref | output | REF_W | Reference of the classified packet |
| out_qid | output | 3 | Queue number assigned to the packet |

## Verification
The hardest situation to reach is a table write that lands while a scan is still running or while a result is blocked by downstream backpressure. The bench creates it by asserting `cfg_we` in the cycle right after an accept, and again while `out_ready` is held low. It then classifies a packet that only the dropped rule would have caught, and the packet must still go to queue 7. A randomized phase then mixes writes, offered packets and backpressure freely. A cycle-level model checks `in_ready`, `out_valid`, `out_qid` and `out_ref` against the design on every clock.

// File: rtl/pkt_cls_pkg.sv
package pkt_cls_pkg;
  localparam int QID_W      = 3;
  localparam int NUM_QUEUES = 1 << QID_W;
  localparam logic [QID_W-1:0] UNCLS_QID = QID_W'(NUM_QUEUES - 1);

  typedef struct packed {
    logic [7:0]  proto;
    logic [7:0]  tos;
    logic [31:0] src;
    logic [31:0] dst;
  } hdr_t;

  localparam int HDR_W = $bits(hdr_t);

  typedef struct packed {
    logic             en;
    logic [QID_W-1:0] qid;
    hdr_t             value;
    hdr_t             mask;
  } rule_t;

  // a rule hits when no masked bit differs
  function automatic logic rule_hit(hdr_t h, rule_t r);
    logic [HDR_W-1:0] diff;
    diff = (HDR_W'(h) ^ HDR_W'(r.value)) & HDR_W'(r.mask);
    return r.en && (diff == '0);
  endfunction
endpackage

// File: rtl/pkt_cls_table.sv
module pkt_cls_table
  import pkt_cls_pkg::*;
#(
  parameter int NUM_RULES = 8,
  parameter int IDX_W     = $clog2(NUM_RULES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  rule_t            wr_rule,
  input  logic [IDX_W-1:0] rd_idx,
  output rule_t            rd_rule
);
  rule_t [NUM_RULES-1:0] tbl_q;
  logic wr_fire;

  assign wr_fire = wr_en && !lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (wr_fire) begin
      for (int i = 0; i < NUM_RULES; i++) begin
        if (wr_idx == IDX_W'(i)) tbl_q[i] <= wr_rule;
      end
    end
  end

  assign rd_rule = tbl_q[rd_idx];

  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock) |=> $stable(tbl_q)); // R8
endmodule

// File: rtl/pkt_cls_match.sv
module pkt_cls_match
  import pkt_cls_pkg::*;
(
  input  hdr_t  hdr,
  input  rule_t rule,
  output logic  hit
);
  assign hit = rule_hit(hdr, rule);
endmodule

// File: rtl/pkt_cls_seq.sv
module pkt_cls_seq
  import pkt_cls_pkg::*;
#(
  parameter int REF_W     = 16,
  parameter int NUM_RULES = 8,
  parameter int IDX_W     = $clog2(NUM_RULES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [REF_W-1:0] in_ref,
  input  hdr_t             in_hdr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [REF_W-1:0] out_ref,
  output logic [QID_W-1:0] out_qid,
  output hdr_t             scan_hdr,
  output logic [IDX_W-1:0] scan_idx,
  input  logic             cur_hit,
  input  logic [QID_W-1:0] cur_qid,
  output logic             busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_HOLD} st_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RULES - 1);

  st_e              st_q;
  hdr_t             hdr_q;
  logic [REF_W-1:0] ref_q;
  logic [IDX_W-1:0] idx_q;
  logic [QID_W-1:0] qid_q;

  logic scanning, at_last, hit_evt, miss_evt;

  assign scanning = (st_q == ST_SCAN);
  assign at_last  = (idx_q == LAST_IDX);
  assign hit_evt  = scanning && cur_hit;
  assign miss_evt = scanning && !cur_hit && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      hdr_q <= '0;
      ref_q <= '0;
      idx_q <= '0;
      qid_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (in_valid) begin
          hdr_q <= in_hdr;
          ref_q <= in_ref;
          idx_q <= '0;
          st_q  <= ST_SCAN;
        end
        ST_SCAN: begin
          if (hit_evt) begin
            qid_q <= cur_qid;
            st_q  <= ST_HOLD;
          end else if (miss_evt) begin
            qid_q <= UNCLS_QID;
            st_q  <= ST_HOLD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_HOLD: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_HOLD);
  assign out_ref   = ref_q;
  assign out_qid   = qid_q;
  assign scan_hdr  = hdr_q;
  assign scan_idx  = idx_q;
  assign busy      = (st_q != ST_IDLE);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_qid) && $stable(out_ref))); // R7
  AST_HIT_TO_QID: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (out_valid && out_qid == $past(cur_qid))); // R3
  AST_MISS_TO_UNCLS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (out_valid && out_qid == UNCLS_QID)); // R4
  AST_SCAN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && at_last) |=> !scanning); // R6
endmodule

// File: rtl/pkt_cls.sv
module pkt_cls
  import pkt_cls_pkg::*;
#(
  parameter int REF_W     = 16,
  parameter int NUM_RULES = 8,
  parameter int IDX_W     = $clog2(NUM_RULES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [REF_W-1:0] in_ref,
  input  logic [7:0]       in_proto,
  input  logic [7:0]       in_tos,
  input  logic [31:0]      in_src,
  input  logic [31:0]      in_dst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic [2:0]       cfg_qid,
  input  logic [79:0]      cfg_value,
  input  logic [79:0]      cfg_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [REF_W-1:0] out_ref,
  output logic [2:0]       out_qid
);
  hdr_t             in_hdr, scan_hdr;
  rule_t            wr_rule, cur_rule;
  logic [IDX_W-1:0] scan_idx;
  logic             cur_hit, busy;

  assign in_hdr        = '{proto: in_proto, tos: in_tos, src: in_src, dst: in_dst};
  assign wr_rule.en    = cfg_en;
  assign wr_rule.qid   = cfg_qid;
  assign wr_rule.value = hdr_t'(cfg_value);
  assign wr_rule.mask  = hdr_t'(cfg_mask);

  pkt_cls_table #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .lock(busy),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_rule(wr_rule),
    .rd_idx(scan_idx), .rd_rule(cur_rule)
  );

  pkt_cls_match u_match (.hdr(scan_hdr), .rule(cur_rule), .hit(cur_hit));

  pkt_cls_seq #(.REF_W(REF_W), .NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_ref(in_ref), .in_hdr(in_hdr),
    .out_valid(out_valid), .out_ready(out_ready), .out_ref(out_ref), .out_qid(out_qid),
    .scan_hdr(scan_hdr), .scan_idx(scan_idx),
    .cur_hit(cur_hit), .cur_qid(cur_rule.qid), .busy(busy)
  );
endmodule

// File: tb/pkt_cls_tb.sv
module pkt_cls_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [15:0] in_ref = 0, out_ref;
  logic [79:0] in_hdr = 0;
  logic cfg_we = 0, cfg_en = 0;
  logic [IW-1:0] cfg_idx = 0;
  logic [2:0] cfg_qid = 0, out_qid;
  logic [79:0] cfg_value = 0, cfg_mask = 0;

  pkt_cls #(.REF_W(16), .NUM_RULES(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_ref(in_ref),
    .in_proto(in_hdr[79:72]), .in_tos(in_hdr[71:64]), .in_src(in_hdr[63:32]), .in_dst(in_hdr[31:0]),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_qid(cfg_qid),
    .cfg_value(cfg_value), .cfg_mask(cfg_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_ref(out_ref), .out_qid(out_qid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 scanning, 2 holding
  int m_st = 0, m_idx = 0;
  logic [79:0] m_hdr;
  logic [15:0] m_ref;
  logic [2:0]  m_q;
  bit          m_en  [NR];
  logic [2:0]  m_rq  [NR];
  logic [79:0] m_val [NR];
  logic [79:0] m_msk [NR];

  function automatic bit fld_eq(logic [31:0] a, logic [31:0] v, logic [31:0] m);
    return (a & m) == (v & m);
  endfunction

  function automatic bit model_match(logic [79:0] h, logic [79:0] v, logic [79:0] m);
    return fld_eq({24'd0, h[79:72]}, {24'd0, v[79:72]}, {24'd0, m[79:72]}) &&
           fld_eq({24'd0, h[71:64]}, {24'd0, v[71:64]}, {24'd0, m[71:64]}) &&
           fld_eq(h[63:32], v[63:32], m[63:32]) &&
           fld_eq(h[31:0], v[31:0], m[31:0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_q = 0; m_ref = 0; m_hdr = 0;
      for (int i = 0; i < NR; i++) begin m_en[i] = 0; m_rq[i] = 0; m_val[i] = 0; m_msk[i] = 0; end
    end else begin
      case (m_st)
        0: begin
          if (cfg_we) begin
            m_en[cfg_idx] = cfg_en; m_rq[cfg_idx] = cfg_qid;
            m_val[cfg_idx] = cfg_value; m_msk[cfg_idx] = cfg_mask;
          end
          if (in_valid) begin m_hdr = in_hdr; m_ref = in_ref; m_idx = 0; m_st = 1; end
        end
        1: begin
          if (m_en[m_idx] && model_match(m_hdr, m_val[m_idx], m_msk[m_idx])) begin
            m_q = m_rq[m_idx]; m_st = 2;
          end else if (m_idx == NR - 1) begin
            m_q = 3'd7; m_st = 2;
          end else m_idx++;
        end
        default: if (out_ready) m_st = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 in_ready", 32'(in_ready), 32'(m_st == 0));
      chk("R6 out_valid", 32'(out_valid), 32'(m_st == 2));
      if (m_st == 2) begin
        chk("R3 out_qid", 32'(out_qid), 32'(m_q));
        chk("R9 out_ref", 32'(out_ref), 32'(m_ref));
      end
    end
  end

  task automatic report();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  function automatic logic [79:0] hdr(logic [7:0] p, logic [7:0] t, logic [31:0] s, logic [31:0] d);
    return {p, t, s, d};
  endfunction

  task automatic write_rule(int idx, bit en, logic [2:0] q, logic [79:0] v, logic [79:0] m);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_en = en; cfg_qid = q; cfg_value = v; cfg_mask = m;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_result(int max_lat, output int lat);
    lat = 0;
    while (!out_valid && lat < max_lat) begin @(negedge clk); lat++; end
  endtask

  task automatic send(logic [15:0] r, logic [79:0] h, logic [2:0] exp_q, int exp_lat, string tag);
    int lat;
    @(negedge clk);
    in_valid = 1; in_ref = r; in_hdr = h;
    @(negedge clk);
    in_valid = 0;
    wait_result(40, lat);
    chk(tag, 32'(out_qid), 32'(exp_q));
    chk({tag, " R6 latency"}, 32'(lat), 32'(exp_lat));
    chk({tag, " R9 ref"}, 32'(out_ref), 32'(r));
  endtask

  localparam logic [79:0] M_PROTO = {8'hFF, 72'd0};
  localparam logic [79:0] M_TOS   = {8'h00, 8'hFF, 64'd0};
  localparam logic [79:0] M_DST8  = {48'd0, 32'hFF00_0000};

  initial begin
    int lat;
    logic [79:0] pick_m;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset in_ready", 32'(in_ready), 1);
    chk("R1 reset out_valid", 32'(out_valid), 0);
    send(16'h0001, hdr(8'd6, 8'h00, 32'h0102_0304, 32'h0B00_0001), 3'd7, NR, "R1 empty table");

    write_rule(0, 1, 3'd1, hdr(8'd6, 0, 0, 0), M_PROTO);
    write_rule(2, 1, 3'd3, hdr(0, 0, 0, 32'h0A00_0000), M_DST8);
    write_rule(3, 1, 3'd5, hdr(0, 8'hB8, 0, 0), M_TOS);
    write_rule(4, 0, 3'd2, 80'd0, 80'd0);

    send(16'h0010, hdr(8'd6, 8'h00, 32'h1, 32'h0B00_0001), 3'd1, 1, "R2 protocol match");
    send(16'h0011, hdr(8'd17, 8'h00, 32'h1, 32'h0A01_0203), 3'd3, 3, "R2 dest prefix match");
    send(16'h0012, hdr(8'd17, 8'h00, 32'h1, 32'h0B01_0203), 3'd7, NR, "R4 no rule matches");
    send(16'h0013, hdr(8'd17, 8'hB8, 32'h1, 32'h0A01_0203), 3'd3, 3, "R3 lower index wins");
    send(16'h0014, hdr(8'd6, 8'hB8, 32'h1, 32'h0A01_0203), 3'd1, 1, "R3 rule 0 first");
    send(16'h0015, hdr(8'd17, 8'hB8, 32'h1, 32'h0B01_0203), 3'd5, 4, "R3 later rule");
    send(16'h0016, hdr(8'd1, 8'h00, 32'h1, 32'h0C00_0000), 3'd7, NR, "R5 disabled catch-all");

    // R8: write during scan and during held result
    @(negedge clk);
    in_valid = 1; in_ref = 16'h0020; in_hdr = hdr(8'd1, 8'h00, 32'h2, 32'h0C00_0000);
    out_ready = 0;
    @(negedge clk);
    in_valid = 0;
    cfg_we = 1; cfg_idx = 3'd1; cfg_en = 1; cfg_qid = 3'd6; cfg_value = 0; cfg_mask = 0;
    @(negedge clk);
    cfg_we = 0;
    wait_result(40, lat);
    chk("R8 scan ignores write", 32'(out_qid), 7);
    cfg_we = 1; cfg_idx = 3'd5; cfg_en = 1; cfg_qid = 3'd6; cfg_value = 0; cfg_mask = 0;
    @(negedge clk);
    cfg_we = 0;
    repeat (3) @(negedge clk);
    chk("R7 held under backpressure", 32'(out_valid), 1);
    chk("R7 held qid", 32'(out_qid), 7);
    chk("R7 in_ready low while held", 32'(in_ready), 0);
    out_ready = 1;
    send(16'h0021, hdr(8'd1, 8'h00, 32'h3, 32'h0C00_0000), 3'd7, NR, "R8 table unchanged");

    write_rule(7, 1, 3'd0, 80'd0, 80'd0);
    send(16'h0030, hdr(8'd1, 8'h00, 32'h3, 32'h0C00_0000), 3'd0, NR, "R3 last rule catch-all");
    write_rule(0, 0, 3'd1, hdr(8'd6, 0, 0, 0), M_PROTO);
    send(16'h0031, hdr(8'd6, 8'h00, 32'h3, 32'h0C00_0000), 3'd0, NR, "R5 rule disabled");

    // mixed random traffic checked by the model every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 2) != 0);
      in_ref = 16'($urandom);
      in_hdr = hdr(($urandom_range(0, 1) != 0) ? 8'd6 : 8'd17,
                   ($urandom_range(0, 1) != 0) ? 8'hB8 : 8'h00,
                   $urandom,
                   {($urandom_range(0, 1) != 0) ? 8'h0A : 8'h0B, 24'($urandom)});
      out_ready = ($urandom_range(0, 3) != 0);
      cfg_we = ($urandom_range(0, 9) == 0);
      cfg_idx = IW'($urandom_range(0, NR - 1));
      cfg_en = ($urandom_range(0, 3) != 0);
      cfg_qid = 3'($urandom);
      case ($urandom_range(0, 3))
        0: pick_m = M_PROTO;
        1: pick_m = M_TOS;
        2: pick_m = M_DST8;
        default: pick_m = 80'd0;
      endcase
      cfg_mask = pick_m;
      cfg_value = hdr(($urandom_range(0, 1) != 0) ? 8'd6 : 8'd17, 8'hB8, 0,
                      ($urandom_range(0, 1) != 0) ? 32'h0A00_0000 : 32'h0B00_0000);
    end
    @(negedge clk);
    in_valid = 0; cfg_we = 0; out_ready = 1;
    repeat (20) @(negedge clk);
    report();
  end
endmodule